// File: doc/BRIEF.md
# Receive Byte Buffer with Hardware Handshake

This block sits between a serial receiver and whatever consumes its bytes. Incoming bytes are held in a first-in first-out store of 576 entries. While that store is filling, the block tells the far end to pause by raising the active-low ready-to-send line once 383 bytes are waiting. It lowers the line again as soon as the consumer drains the level below that mark.

For the outgoing direction the block watches the far end's active-low clear-to-send line. It passes that line through a two-stage synchronizer. A transmitter asks to send a byte with `txReq`, and the block answers on `txGrant` in the same cycle. After a stop is seen, only two more grants are issued until clear-to-send returns low. A flush input empties the store at once, for example when the port is opened. When the flow-control enable is low, the handshake is switched off: ready-to-send stays low and clear-to-send is ignored.

Top module: `rxbuf_flowctl`

## Requirements
- R1: Bytes leave in the order they were accepted. `rdValid` is high whenever the store is non-empty, and `rdData` shows the oldest byte. A byte is removed on a cycle where `rdValid` and `rdReady` are both high. The store holds up to 576 bytes.
- R2: With flow control enabled, `rtsN` is low while fewer than 383 bytes are held. It is high from the cycle after the write that brings the level to 383.
- R3: `rtsN` returns low in the cycle after a read brings the level from 383 down to 382.
- R4: A write arriving while 576 bytes are held is dropped, and the stored data is unchanged. `overflow` goes high on the next cycle and stays high until a flush or reset.
- R5: A change on `ctsN` affects `txGrant` only after two rising clock edges.
- R6: Once the synchronized `ctsN` is high, at most two requests are granted. Further requests get `txGrant` low. The allowance of two is restored after the synchronized `ctsN` has been low for one cycle.
- R7: `flush` empties the store and clears `overflow` on the next edge. Any read or write in the same cycle is discarded.
- R8: With `flowEn` low, `rtsN` is low whatever the level, and `txGrant` equals `txReq` whatever `ctsN` is.
- R9: After reset the store is empty (`rdValid` low, `level` 0), `rtsN` is low and `overflow` is low.
- R10: `level` reports the number of bytes held, updated on the edge that accepts a write or a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flowEn | input | 1 | Enables both handshake directions |
| flush | input | 1 | Empties the store |
| wrValid | input | 1 | Byte from the receiver is present |
| wrData | input | 8 | Received byte |
| rdReady | input | 1 | Consumer takes the head byte |
| rdValid | output | 1 | Store is non-empty |
| rdData | output | 8 | Oldest stored byte |
| level | output | 10 | Number of bytes held |
| overflow | output | 1 | Sticky dropped-write flag |
| rtsN | output | 1 | Active-low ready-to-send to the far end |
| ctsN | input | 1 | Active-low clear-to-send from the far end |
| txReq | input | 1 | Transmitter asks to send a byte |
| txGrant | output | 1 | Permission for that byte |

## Verification
The bench drives the level to exactly 382, 383 and back to 382, to catch an off-by-one watermark that would raise or drop `rtsN` one byte early or late. It fills all 576 entries and then writes once more. A design that wrapped its pointers wrongly would then return corrupted data, and one without the drop rule would lose the oldest byte. The bench counts grants after raising `ctsN`, across the synchronizer delay and across a second stop episode. This catches a budget of one or three, a missing synchronizer stage, or a counter that never resets. Flush and the disabled mode are checked with the store well above the watermark and `ctsN` high, where a stale flag or stuck handshake would show.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifoStrobe_t;
endpackage

// File: rtl/rxbuf_datapath.sv
module rxbuf_datapath
  import rxbuf_pkg::*;
#(
  parameter int Depth = 576,
  parameter int DataW = 8,
  localparam int PtrW = $clog2(Depth),
  localparam int CntW = $clog2(Depth + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DataW-1:0]  wrData,
  output logic [DataW-1:0]  rdData,
  output logic [CntW-1:0]   count
);
  localparam logic [PtrW-1:0] LastPtr = PtrW'(Depth - 1);
  localparam logic [CntW-1:0] FullCnt = CntW'(Depth);

  logic [DataW-1:0] mem [Depth];
  logic [PtrW-1:0]  wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LastPtr) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == LastPtr) ? '0 : rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdData = mem[rdPtr];

  // R4: control never pushes into a full store
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (count != FullCnt));
  // R1: level never exceeds capacity
  p_capacity_r1: assert property (@(posedge clk) disable iff (!rstN)
    count <= FullCnt);
  // R7: a flush leaves the store empty
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (count == '0));
endmodule

// File: rtl/rxbuf_control.sv
module rxbuf_control
  import rxbuf_pkg::*;
#(
  parameter int Depth     = 576,
  parameter int StopLevel = 383,
  parameter int TxSlack   = 2,
  localparam int CntW  = $clog2(Depth + 1),
  localparam int SlkW  = $clog2(TxSlack + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flowEn,
  input  logic             flush,
  input  logic             wrValid,
  input  logic             rdReady,
  input  logic [CntW-1:0]  count,
  output fifoStrobe_t      strobe,
  output logic             rdValid,
  output logic             overflow,
  output logic             rtsN,
  input  logic             ctsN,
  input  logic             txReq,
  output logic             txGrant
);
  localparam logic [CntW-1:0] FullCnt = CntW'(Depth);
  localparam logic [CntW-1:0] StopCnt = CntW'(StopLevel);
  localparam logic [SlkW-1:0] SlackCnt = SlkW'(TxSlack);

  logic full;
  logic ctsMeta, ctsSync;
  logic stopSeen;
  logic [SlkW-1:0] sentAfterStop;

  assign full    = (count == FullCnt);
  assign rdValid = (count != '0);

  always_comb begin
    strobe.clear = flush;
    strobe.push  = wrValid && !full && !flush;
    strobe.pop   = rdReady && rdValid && !flush;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush)          overflow <= 1'b0;
    else if (wrValid && full)    overflow <= 1'b1;
  end

  assign rtsN = flowEn && (count >= StopCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctsMeta <= 1'b0;
      ctsSync <= 1'b0;
    end else begin
      ctsMeta <= ctsN;
      ctsSync <= ctsMeta;
    end
  end

  assign stopSeen = flowEn && ctsSync;
  assign txGrant  = txReq && (!stopSeen || (sentAfterStop < SlackCnt));

  always_ff @(posedge clk) begin
    if (!rstN || !stopSeen)          sentAfterStop <= '0;
    else if (txGrant)                sentAfterStop <= sentAfterStop + 1'b1;
  end

  // R2: reaching the watermark raises RTS on the next cycle
  p_rts_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !strobe.pop && count == StopCnt - 1'b1 && flowEn)
      |=> (rtsN || !flowEn));
  // R3: draining below the watermark lowers RTS
  p_rts_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && !strobe.push && count == StopCnt) |=> !rtsN);
  // R6: stop budget is never exceeded
  p_budget_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stopSeen && $past(stopSeen) && sentAfterStop == SlackCnt) |-> !txGrant);
  // R8: disabled handshake passes requests through
  p_flow_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !flowEn |-> (!rtsN && (txGrant == txReq)));
  // R4: a dropped write sets the sticky flag
  p_overflow_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && full && !flush) |=> overflow);
endmodule

// File: rtl/rxbuf_flowctl.sv
module rxbuf_flowctl
  import rxbuf_pkg::*;
#(
  parameter int Depth     = 576,
  parameter int DataW     = 8,
  parameter int StopLevel = 383,
  parameter int TxSlack   = 2,
  localparam int CntW = $clog2(Depth + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flowEn,
  input  logic              flush,
  input  logic              wrValid,
  input  logic [DataW-1:0]  wrData,
  input  logic              rdReady,
  output logic              rdValid,
  output logic [DataW-1:0]  rdData,
  output logic [CntW-1:0]   level,
  output logic              overflow,
  output logic              rtsN,
  input  logic              ctsN,
  input  logic              txReq,
  output logic              txGrant
);
  fifoStrobe_t strobe;

  rxbuf_control #(.Depth(Depth), .StopLevel(StopLevel), .TxSlack(TxSlack)) u_ctrl (
    .clk(clk), .rstN(rstN), .flowEn(flowEn), .flush(flush),
    .wrValid(wrValid), .rdReady(rdReady), .count(level),
    .strobe(strobe), .rdValid(rdValid), .overflow(overflow),
    .rtsN(rtsN), .ctsN(ctsN), .txReq(txReq), .txGrant(txGrant)
  );

  rxbuf_datapath #(.Depth(Depth), .DataW(DataW)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(wrData), .rdData(rdData), .count(level)
  );
endmodule

// File: tb/rxbuf_flowctl_bench.sv
module rxbuf_flowctl_bench;
  localparam int Depth = 576;
  localparam int Stop  = 383;

  logic clk = 1'b0;
  logic rstN = 1'b0, flowEn = 1'b1, flush = 1'b0;
  logic wrValid = 1'b0, rdReady = 1'b0, ctsN = 1'b0, txReq = 1'b0;
  logic [7:0] wrData = '0;
  logic rdValid, overflow, rtsN, txGrant;
  logic [7:0] rdData;
  logic [9:0] level;

  int checks = 0, fails = 0, modelCount = 0;
  bit done = 0;
  logic [7:0] expQ[$];

  always #2 clk = ~clk;

  rxbuf_flowctl u_rxbuf_flowctl (
    .clk(clk), .rstN(rstN), .flowEn(flowEn), .flush(flush),
    .wrValid(wrValid), .wrData(wrData), .rdReady(rdReady),
    .rdValid(rdValid), .rdData(rdData), .level(level), .overflow(overflow),
    .rtsN(rtsN), .ctsN(ctsN), .txReq(txReq), .txGrant(txGrant)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver: one write per cycle, expected byte queued if it should be kept
  task automatic writeByte(input logic [7:0] d);
    wrValid = 1'b1; wrData = d;
    if (modelCount < Depth) begin expQ.push_back(d); modelCount++; end
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic fillTo(input int target);
    while (modelCount < target) writeByte(8'(modelCount * 7 + 3));
  endtask

  // monitor: compare head against scoreboard, then consume it
  task automatic readByte();
    logic [7:0] e;
    e = expQ.pop_front();
    check(rdValid == 1'b1, "R1 rdValid", int'(rdValid), 1);
    check(rdData == e, "R1 order", int'(rdData), int'(e));
    rdReady = 1'b1; modelCount--;
    @(negedge clk);
    rdReady = 1'b0;
  endtask

  task automatic doFlush();
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    expQ.delete(); modelCount = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int grants;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(rdValid == 0, "R9 rdValid", int'(rdValid), 0);
    check(level == 0, "R9 level", int'(level), 0);
    check(rtsN == 0, "R9 rtsN", int'(rtsN), 0);
    check(overflow == 0, "R9 overflow", int'(overflow), 0);

    // R1/R10 small transfer
    for (int i = 0; i < 5; i++) writeByte(8'hA0 + 8'(i));
    check(level == 5, "R10 level", int'(level), 5);
    for (int i = 0; i < 5; i++) readByte();
    check(rdValid == 0, "R1 empty", int'(rdValid), 0);

    // R2 watermark edge
    fillTo(Stop - 1);
    check(rtsN == 0, "R2 below mark", int'(rtsN), 0);
    writeByte(8'h77);
    check(level == Stop, "R10 level at mark", int'(level), Stop);
    check(rtsN == 1, "R2 at mark", int'(rtsN), 1);
    // R3 one read drops it
    readByte();
    check(rtsN == 0, "R3 below mark", int'(rtsN), 0);

    // R4 full and dropped write
    fillTo(Depth);
    check(level == Depth, "R1 capacity", int'(level), Depth);
    check(overflow == 0, "R4 no flag yet", int'(overflow), 0);
    writeByte(8'hEE);
    check(overflow == 1, "R4 flag set", int'(overflow), 1);
    check(level == Depth, "R4 level kept", int'(level), Depth);
    while (modelCount > 0) readByte();
    check(overflow == 1, "R4 sticky", int'(overflow), 1);

    // R7 flush with pending data and flag
    for (int i = 0; i < 10; i++) writeByte(8'(i));
    doFlush();
    check(rdValid == 0, "R7 empty", int'(rdValid), 0);
    check(level == 0, "R7 level", int'(level), 0);
    check(overflow == 0, "R7 flag cleared", int'(overflow), 0);
    writeByte(8'h3C); readByte();

    // R5/R6 transmit gating
    txReq = 1'b1;
    @(negedge clk);
    check(txGrant == 1, "R6 clear to send", int'(txGrant), 1);
    for (int ep = 0; ep < 2; ep++) begin
      ctsN = 1'b1;
      @(negedge clk);
      check(txGrant == 1, "R5 sync delay", int'(txGrant), 1);
      grants = 0;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        if (txGrant) grants++;
      end
      check(grants == 2, "R6 grants after stop", grants, 2);
      check(txGrant == 0, "R6 held off", int'(txGrant), 0);
      ctsN = 1'b0;
      @(negedge clk);
      check(txGrant == 0, "R5 release delay", int'(txGrant), 0);
      repeat (3) @(negedge clk);
      check(txGrant == 1, "R6 resumed", int'(txGrant), 1);
    end

    // R8 handshake disabled
    flowEn = 1'b0; ctsN = 1'b1;
    repeat (3) @(negedge clk);
    check(txGrant == 1, "R8 grant follows req", int'(txGrant), 1);
    txReq = 1'b0; #0;
    check(txGrant == 0, "R8 no req", int'(txGrant), 0);
    fillTo(400);
    check(rtsN == 0, "R8 rts held low", int'(rtsN), 0);
    flowEn = 1'b1; #0;
    check(rtsN == 1, "R2 rts after enable", int'(rtsN), 1);
    doFlush();
    check(rtsN == 0, "R7 rts after flush", int'(rtsN), 0);
    finishRun();
  end
endmodule